// File: doc/BRIEF.md
# Programmable Symmetric Baud-Rate Timer

This block produces a symmetric square wave for use as the 16x sampling clock of a serial receiver or transmitter. A 16-bit divisor is written from a host bus as two separate byte registers, an upper byte and a lower byte. The block counts pulses from one of eight clock sources, chosen by a 3-bit select field. Each half of the output wave lasts exactly as many selected-source pulses as the divisor value. The output frequency is therefore the source rate divided by twice the divisor. To get a given data rate, program the divisor for sixteen times that rate.

Source clocks come in as single-cycle enable pulses in the main clock domain. A control byte sets the source select and a run bit. Setting run when the timer is stopped loads the divisor and starts counting. Clearing run freezes the counter and the output. Besides the wave, the block gives a one-cycle tick each time the wave rises, which a serial shifter can use as its 16x enable.

Top module: `baud_div_timer`

## Requirements
- R1: After reset, wave_o is low, tick_o is low and the timer is stopped.
- R2: While running, wave_o toggles once every D pulses of the selected source. D is {upper byte, lower byte}. Register address 0 holds the upper byte and address 1 holds the lower byte.
- R3: A divisor value of zero gives a half period of 65536 selected-source pulses.
- R4: tick_o is high for exactly one cycle, in the cycle in which wave_o becomes high, and at no other time.
- R5: Bits [2:0] of the control byte (address 2) pick which bit of src_pulse_i advances the counter. Pulses on the other seven sources have no effect.
- R6: Writing the control byte with bit 3 set while the timer is stopped loads the divisor into the counter and starts the count. The first half period then lasts D pulses.
- R7: Writing the control byte with bit 3 clear stops the timer. Counter and wave_o then hold through any number of source pulses. A later start reloads the full divisor.
- R8: A write to either preset byte during a half period leaves that half period unchanged. The new value sets the length of the following halves.
- R9: A control write with bit 3 set while the timer is already running changes the selected source without reloading the counter.
- R10: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse_i | input | 8 | One-cycle enable pulses from the eight clock sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 upper byte, 1 lower byte, 2 control, 3 unused |
| wr_data_i | input | 8 | Write data; control byte: [2:0] source, [3] run |
| wave_o | output | 1 | Symmetric square wave |
| tick_o | output | 1 | One-cycle pulse on each rising edge of wave_o |

## Verification
The main function is swept over all eight sources, each with divisors 1, 2, 3 and 7. Every selected pulse is preceded by a cycle in which all the other sources pulse. This catches a wrong bit in the multiplexer, an off-by-one in the half period, and a tick that lands on the wrong edge. Continuous pulse trains with divisors 258 and 0 show whether the upper byte sits in the right place and whether the zero divisor wraps to 65536. Short sequences cover the control cases. Stopping and restarting tells a hold with reload apart from a resume. A preset write in mid-half tells a deferred reload apart from an immediate one. A source change while running shows whether a control write reloads the counter.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

    localparam int DEF_BYTE_W  = 8;
    localparam int DEF_NUM_SRC = 8;

    // bit of the control byte that carries the run command
    localparam int CTRL_RUN_BIT = 3;

    typedef enum logic [1:0] {
        ADDR_DIV_HI = 2'd0,
        ADDR_DIV_LO = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/bdt_regs.sv
module bdt_regs
    import bdt_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int SEL_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [2*BYTE_W-1:0]   preset,
    output logic [SEL_W-1:0]      src_sel,
    output logic                  run,
    output logic                  start
);
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic [SEL_W-1:0]  sel_q;
    logic              run_q;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(wr_addr);

    // start: a run command that arrives while stopped
    always_comb begin
        start = wr_en && (addr == ADDR_CTRL) && wr_data[CTRL_RUN_BIT] && !run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            sel_q <= '0;
            run_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADDR_DIV_HI: hi_q <= wr_data;
                ADDR_DIV_LO: lo_q <= wr_data;
                ADDR_CTRL: begin
                    sel_q <= wr_data[SEL_W-1:0];
                    run_q <= wr_data[CTRL_RUN_BIT];
                end
                default: ;
            endcase
        end
    end

    assign preset  = {hi_q, lo_q};
    assign src_sel = sel_q;
    assign run     = run_q;
endmodule

// File: rtl/bdt_src_mux.sv
module bdt_src_mux #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    output logic               step
);
    always_comb begin
        step = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) step = src[i];
        end
    end
endmodule

// File: rtl/bdt_counter.sv
module bdt_counter #(
    parameter int DIV_W = 16,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] preset,
    output logic             wave,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);
    // a zero divisor stands for the full range
    function automatic logic [CNT_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        if (d == '0) return CNT_W'(1) << DIV_W;
        return {1'b0, d};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wave <= 1'b0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (start) begin
                cnt <= eff_div(preset);
            end else if (run && step) begin
                if (cnt == CNT_W'(1)) begin
                    cnt  <= eff_div(preset);
                    wave <= ~wave;
                    tick <= ~wave;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/baud_div_timer.sv
module baud_div_timer
    import bdt_pkg::*;
#(
    parameter int BYTE_W  = DEF_BYTE_W,
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_pulse_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    output logic               wave_o,
    output logic               tick_o
);
    localparam int DIV_W = 2 * BYTE_W;
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] preset_w;
    logic [SEL_W-1:0] sel_w;
    logic             run_w, start_w, step_w;
    logic [CNT_W-1:0] cnt_w;

    bdt_regs #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .preset(preset_w), .src_sel(sel_w), .run(run_w), .start(start_w)
    );

    bdt_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
        .src(src_pulse_i), .sel(sel_w), .step(step_w)
    );

    bdt_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst(rst),
        .start(start_w), .run(run_w), .step(step_w), .preset(preset_w),
        .wave(wave_o), .tick(tick_o), .cnt(cnt_w)
    );
endmodule

// File: rtl/bdt_checker.sv
module bdt_checker #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             step,
    input logic [CNT_W-1:0] cnt,
    input logic             wave,
    input logic             tick
);
    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (!wave && !tick));

    // R4
    tick_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (wave && !$past(wave)));

    // R4
    rise_has_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wave) |-> tick);

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!run) |-> $stable(wave));

    // R2
    toggle_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wave != $past(wave)) |-> $past(run && step));

    // R3
    cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt != '0 && cnt <= (CNT_W'(1) << (CNT_W-1))));
endmodule

bind baud_div_timer bdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run(run_w), .step(step_w),
    .cnt(cnt_w), .wave(wave_o), .tick(tick_o)
);

// File: tb/baud_div_timer_bench.sv
module baud_div_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wave, tick;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    baud_div_timer u_baud_div_timer (
        .clk(clk), .rst(rst), .src_pulse_i(src),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .wave_o(wave), .tick_o(tick)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src = 8'(1 << s);
        @(negedge clk);
        src = '0;
    endtask

    task automatic others(input int s);
        @(negedge clk);
        src = ~8'(1 << s);
        @(negedge clk);
        src = '0;
    endtask

    task automatic train(input int s, input int n);
        @(negedge clk);
        src = 8'(1 << s);
        repeat (n) @(negedge clk);
        src = '0;
    endtask

    task automatic setup(input int s, input logic [15:0] d);
        wr(2'd2, 8'(s));
        wr(2'd0, d[15:8]);
        wr(2'd1, d[7:0]);
        wr(2'd2, 8'(s) | 8'h08);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic w0, ew;
        int divs [4] = '{1, 2, 3, 7};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, and stopped: pulses do nothing
        check("R1 wave", wave, 1'b0);
        check("R1 tick", tick, 1'b0);
        wr(2'd1, 8'd1);
        pulse(0);
        check("R1 stopped", wave, 1'b0);

        // R2 R4 R5 R6: sweep of sources and small divisors
        for (int s = 0; s < 8; s++) begin
            for (int di = 0; di < 4; di++) begin
                int d = divs[di];
                setup(s, 16'(d));
                w0 = wave;
                for (int k = 1; k <= 4 * d + 1; k++) begin
                    others(s);
                    check("R5 ignored", wave, (((k - 1) / d) % 2 == 1) ? ~w0 : w0);
                    check("R5 ignored tick", tick, 1'b0);
                    pulse(s);
                    ew = ((k / d) % 2 == 1) ? ~w0 : w0;
                    check("R2 wave", wave, ew);
                    check("R4 tick", tick, (k % d == 0) && ew);
                end
            end
        end

        // R2: upper byte placement, divisor 258
        setup(0, 16'h0102);
        w0 = wave;
        train(0, 257);
        check("R2 hi byte no toggle", wave, w0);
        pulse(0);
        check("R2 hi byte toggle", wave, ~w0);

        // R3: zero divisor means 65536
        setup(1, 16'h0000);
        w0 = wave;
        train(1, 65535);
        check("R3 no toggle at 65535", wave, w0);
        pulse(1);
        check("R3 toggle at 65536", wave, ~w0);

        // R7: stop holds, restart reloads
        wr(2'd2, 8'h02);
        setup(2, 16'd3);
        w0 = wave;
        pulse(2); pulse(2);
        wr(2'd2, 8'h02);
        for (int i = 0; i < 5; i++) pulse(2);
        check("R7 hold", wave, w0);
        wr(2'd2, 8'h0A);
        pulse(2);
        check("R7 reload not resume", wave, w0);
        pulse(2);
        check("R7 reload 2", wave, w0);
        pulse(2);
        check("R7 reload toggle", wave, ~w0);

        // R8: preset write mid-half is deferred
        setup(3, 16'd4);
        w0 = wave;
        pulse(3); pulse(3);
        wr(2'd1, 8'd2);
        pulse(3);
        check("R8 half unchanged", wave, w0);
        pulse(3);
        check("R8 old half ends", wave, ~w0);
        pulse(3);
        check("R8 new half mid", wave, ~w0);
        pulse(3);
        check("R8 new half ends", wave, w0);

        // R9: source change while running does not reload
        setup(4, 16'd4);
        w0 = wave;
        pulse(4); pulse(4);
        wr(2'd2, 8'h0D);
        pulse(4);
        check("R9 old source ignored", wave, w0);
        pulse(5);
        check("R9 no reload", wave, w0);
        pulse(5);
        check("R9 toggle", wave, ~w0);

        // R10: address 3 writes do nothing
        setup(6, 16'd2);
        w0 = wave;
        wr(2'd3, 8'h00);
        pulse(6);
        check("R10 no effect", wave, w0);
        pulse(6);
        check("R10 still running", wave, ~w0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule